// File: doc/BRIEF.md
# Odd-Even Turn-Model Route Unit

This unit computes the next hop for a flit at one node of a two-dimensional mesh. It compares the node's own coordinates with the flit's destination and looks at which port the flit came in on. From these it builds a mask of output directions that all shorten the remaining distance. The mask keeps a direction only if the odd-even turn model allows it. The model rules out some turns in even columns and others in odd columns, which keeps wormhole traffic free of deadlock and livelock without needing virtual channels. The unit also picks one direction from the mask, and a per-direction congestion hint steers that choice.

The unit has no memory of where a packet started. Its only history is the port the flit arrived on, which gives the flit's current heading (eastward, westward, vertical, or none for a flit injected at this node). Inputs are registered on each rising clock edge, and the mask and the choice appear one cycle later.

The decode works through named cases rather than states. The geometry case is one of:
- HERE: destination reached.
- COLUMN: same column, different row.
- EAST_ROW or WEST_ROW: same row.
- EAST_DIAG or WEST_DIAG: both coordinates differ.

The heading is one of NONE, EASTWARD, WESTWARD or VERTICAL. Every flit moves from its decoded pair to one registered result per clock.

Top module: `oer_route_unit`

## Requirements
- R1: While reset is asserted, `cand_mask` is 0 and `sel_dir` is 7 (no direction).
- R2: The outputs reflect the inputs sampled at the previous rising clock edge and stay unchanged between edges. Direction codes and mask bit positions are: 0 east (x+1), 1 west (x-1), 2 north (y+1), 3 south (y-1), 4 local.
- R3: When the destination equals the current node, the mask is exactly the local bit (5'b10000) and `sel_dir` is 4, for any arrival port.
- R4: Only distance-reducing directions appear: east only if dst_x > cur_x, west only if dst_x < cur_x, north only if dst_y > cur_y, south only if dst_y < cur_y.
- R5: A flit travelling east (it arrived on the west port, `arr_port` = 1) in an even column (cur_x bit 0 clear) gets neither north nor south.
- R6: A flit travelling vertically (it arrived on the north port, code 2, or the south port, code 3) in an odd column does not get west.
- R7: For a destination to the west, north and south are offered only in an even column.
- R8: East is withheld when dst_x = cur_x + 1, dst_x is even, and dst_y differs from cur_y. The turn must then be taken in the current, odd, column.
- R9: With one candidate, `sel_dir` is that candidate. With one x and one y candidate, it is the y candidate only if the x candidate's hint bit is set and the y candidate's is clear; otherwise it is the x candidate. Hint bit i belongs to direction code i.
- R10: A flit injected at any node and then steered hop by hop by `sel_dir` never meets an empty mask and reaches its destination in exactly the Manhattan distance. When the mask is empty (only possible for arrivals that this routing never produces), `sel_dir` is 7.
- R11: Arrival codes 4 to 7 all mean an injected flit with no prior heading. Codes 0 (east port, travelling west) and 1 to 3 are as above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cur_x | input | X_W | Column of this node |
| cur_y | input | Y_W | Row of this node |
| dst_x | input | X_W | Destination column |
| dst_y | input | Y_W | Destination row |
| arr_port | input | 3 | Port the flit entered on (0 east, 1 west, 2 north, 3 south, 4-7 injected) |
| cong_hint | input | 4 | Congestion hint per direction, bit i for direction code i |
| cand_mask | output | 5 | Allowed minimal directions, bit i for direction code i |
| sel_dir | output | 3 | Chosen direction code, 7 when none |

## Verification
The bench checks every node, destination and arrival combination of the default 8x8 mesh against a behavioural model. Any misplaced parity rule shows up as a mismatch in the mask. A unit that tested column parity on the destination instead of the current node, or that forgot the one-column east lookahead, would still pass most single-hop checks. It would fail on hop-by-hop walks, where a flit steered by the unit's own choices lands in a column whose only useful turn is forbidden and meets an empty mask. A selector that inverted the tie rule, or read the wrong hint bit, would pick north or south where east or west is expected under the mixed hint patterns.

// File: rtl/oer_pkg.sv
package oer_pkg;

    // direction codes double as mask bit positions
    typedef enum logic [2:0] {
        DIR_EAST  = 3'd0,
        DIR_WEST  = 3'd1,
        DIR_NORTH = 3'd2,
        DIR_SOUTH = 3'd3,
        DIR_LOCAL = 3'd4,
        DIR_NONE  = 3'd7
    } dir_e;

    localparam int N_DIRS = 5;
    localparam int B_E = 0;
    localparam int B_W = 1;
    localparam int B_N = 2;
    localparam int B_S = 3;
    localparam int B_L = 4;

    typedef enum logic [1:0] {
        HEAD_NONE,
        HEAD_EASTWARD,
        HEAD_WESTWARD,
        HEAD_VERTICAL
    } heading_e;

    typedef enum logic [2:0] {
        RC_HERE,
        RC_COLUMN,
        RC_EAST_ROW,
        RC_WEST_ROW,
        RC_EAST_DIAG,
        RC_WEST_DIAG
    } route_case_e;

endpackage

// File: rtl/oer_heading.sv
module oer_heading
    import oer_pkg::*;
(
    input  logic [2:0] arr_port,
    output heading_e   heading
);

    // entering on a port means travelling away from that side
    always_comb begin
        unique case (arr_port)
            3'd0:    heading = HEAD_WESTWARD;
            3'd1:    heading = HEAD_EASTWARD;
            3'd2:    heading = HEAD_VERTICAL;
            3'd3:    heading = HEAD_VERTICAL;
            default: heading = HEAD_NONE;
        endcase
    end

endmodule

// File: rtl/oer_min_dirs.sv
module oer_min_dirs
    import oer_pkg::*;
#(
    parameter int X_W = 3,
    parameter int Y_W = 3
) (
    input  logic [X_W-1:0]    cur_x,
    input  logic [Y_W-1:0]    cur_y,
    input  logic [X_W-1:0]    dst_x,
    input  logic [Y_W-1:0]    dst_y,
    output logic [N_DIRS-1:0] base_mask
);

    logic        x_gt, x_lt, y_gt, y_lt, y_ne;
    logic        east_block;
    logic [X_W-1:0] cur_x_inc;
    route_case_e rcase;

    assign x_gt      = dst_x > cur_x;
    assign x_lt      = dst_x < cur_x;
    assign y_gt      = dst_y > cur_y;
    assign y_lt      = dst_y < cur_y;
    assign y_ne      = y_gt | y_lt;
    assign cur_x_inc = cur_x + X_W'(1);
    // stepping into an even destination column would leave a forbidden turn
    assign east_block = (dst_x == cur_x_inc) && !dst_x[0] && y_ne;

    always_comb begin
        if (!x_gt && !x_lt)
            rcase = y_ne ? RC_COLUMN : RC_HERE;
        else if (x_gt)
            rcase = y_ne ? RC_EAST_DIAG : RC_EAST_ROW;
        else
            rcase = y_ne ? RC_WEST_DIAG : RC_WEST_ROW;
    end

    always_comb begin
        base_mask = '0;
        unique case (rcase)
            RC_HERE: begin
                base_mask[B_L] = 1'b1;
            end
            RC_COLUMN: begin
                base_mask[B_N] = y_gt;
                base_mask[B_S] = y_lt;
            end
            RC_EAST_ROW: begin
                base_mask[B_E] = 1'b1;
            end
            RC_WEST_ROW: begin
                base_mask[B_W] = 1'b1;
            end
            RC_EAST_DIAG: begin
                base_mask[B_E] = !east_block;
                base_mask[B_N] = y_gt;
                base_mask[B_S] = y_lt;
            end
            RC_WEST_DIAG: begin
                base_mask[B_W] = 1'b1;
                base_mask[B_N] = y_gt & !cur_x[0];
                base_mask[B_S] = y_lt & !cur_x[0];
            end
            default: base_mask = '0;
        endcase
    end

endmodule

// File: rtl/oer_turn_filter.sv
module oer_turn_filter
    import oer_pkg::*;
(
    input  heading_e          heading,
    input  logic              col_odd,
    input  logic [N_DIRS-1:0] base_mask,
    output logic [N_DIRS-1:0] turn_mask
);

    always_comb begin
        turn_mask = base_mask;
        unique case (heading)
            HEAD_EASTWARD: begin
                if (!col_odd) begin
                    turn_mask[B_N] = 1'b0;
                    turn_mask[B_S] = 1'b0;
                end
            end
            HEAD_VERTICAL: begin
                if (col_odd)
                    turn_mask[B_W] = 1'b0;
            end
            HEAD_WESTWARD: turn_mask = base_mask;
            HEAD_NONE:     turn_mask = base_mask;
        endcase
    end

endmodule

// File: rtl/oer_pick.sv
module oer_pick
    import oer_pkg::*;
(
    input  logic [N_DIRS-1:0] turn_mask,
    input  logic [3:0]        cong_hint,
    output dir_e              pick
);

    logic has_x, has_y, x_busy, y_busy;
    dir_e x_dir, y_dir;

    assign has_x  = turn_mask[B_E] | turn_mask[B_W];
    assign has_y  = turn_mask[B_N] | turn_mask[B_S];
    assign x_dir  = turn_mask[B_E] ? DIR_EAST  : DIR_WEST;
    assign y_dir  = turn_mask[B_N] ? DIR_NORTH : DIR_SOUTH;
    assign x_busy = turn_mask[B_E] ? cong_hint[B_E] : cong_hint[B_W];
    assign y_busy = turn_mask[B_N] ? cong_hint[B_N] : cong_hint[B_S];

    always_comb begin
        if (turn_mask[B_L])
            pick = DIR_LOCAL;
        else if (has_x && has_y)
            pick = (x_busy && !y_busy) ? y_dir : x_dir;
        else if (has_x)
            pick = x_dir;
        else if (has_y)
            pick = y_dir;
        else
            pick = DIR_NONE;
    end

endmodule

// File: rtl/oer_route_unit.sv
module oer_route_unit
    import oer_pkg::*;
#(
    parameter int X_W = 3,
    parameter int Y_W = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [X_W-1:0] cur_x,
    input  logic [Y_W-1:0] cur_y,
    input  logic [X_W-1:0] dst_x,
    input  logic [Y_W-1:0] dst_y,
    input  logic [2:0]     arr_port,
    input  logic [3:0]     cong_hint,
    output logic [4:0]     cand_mask,
    output logic [2:0]     sel_dir
);

    heading_e          heading;
    logic [N_DIRS-1:0] base_mask;
    logic [N_DIRS-1:0] turn_mask;
    dir_e              pick;
    logic [N_DIRS-1:0] mask_q;
    dir_e              sel_q;
    logic              live_q;

    oer_heading u_heading (
        .arr_port (arr_port),
        .heading  (heading)
    );

    oer_min_dirs #(.X_W(X_W), .Y_W(Y_W)) u_min_dirs (
        .cur_x     (cur_x),
        .cur_y     (cur_y),
        .dst_x     (dst_x),
        .dst_y     (dst_y),
        .base_mask (base_mask)
    );

    oer_turn_filter u_turn_filter (
        .heading   (heading),
        .col_odd   (cur_x[0]),
        .base_mask (base_mask),
        .turn_mask (turn_mask)
    );

    oer_pick u_pick (
        .turn_mask (turn_mask),
        .cong_hint (cong_hint),
        .pick      (pick)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '0;
            sel_q  <= DIR_NONE;
            live_q <= 1'b0;
        end else begin
            mask_q <= turn_mask;
            sel_q  <= pick;
            live_q <= 1'b1;
        end
    end

    assign cand_mask = mask_q;
    assign sel_dir   = sel_q;

    // R3: arrival at the destination yields only the local port
    a_r3_local_only: assert property (@(posedge clk) disable iff (!rst_n)
        live_q && $past(dst_x) == $past(cur_x) && $past(dst_y) == $past(cur_y)
        |-> cand_mask == 5'b10000 && sel_dir == 3'd4);

    // R4: every offered direction shortens the distance
    a_r4_minimal: assert property (@(posedge clk) disable iff (!rst_n)
        live_q |-> (!cand_mask[B_E] || $past(dst_x) > $past(cur_x))
                && (!cand_mask[B_W] || $past(dst_x) < $past(cur_x))
                && (!cand_mask[B_N] || $past(dst_y) > $past(cur_y))
                && (!cand_mask[B_S] || $past(dst_y) < $past(cur_y)));

    // R5: eastbound flit in an even column cannot turn north or south
    a_r5_even_east: assert property (@(posedge clk) disable iff (!rst_n)
        live_q && $past(arr_port) == 3'd1 && !$past(cur_x[0])
        |-> !cand_mask[B_N] && !cand_mask[B_S]);

    // R6: vertical flit in an odd column cannot turn west
    a_r6_odd_vert: assert property (@(posedge clk) disable iff (!rst_n)
        live_q && ($past(arr_port) == 3'd2 || $past(arr_port) == 3'd3)
        && $past(cur_x[0]) |-> !cand_mask[B_W]);

    // R7: westward destination offers vertical moves only in even columns
    a_r7_west_vert: assert property (@(posedge clk) disable iff (!rst_n)
        live_q && $past(dst_x) < $past(cur_x) && $past(cur_x[0])
        |-> !cand_mask[B_N] && !cand_mask[B_S]);

    // R8: no step east into an even destination column that still needs a turn
    a_r8_east_hold: assert property (@(posedge clk) disable iff (!rst_n)
        live_q && $past(dst_x) == $past(cur_x) + X_W'(1) && !$past(dst_x[0])
        && $past(dst_y) != $past(cur_y) |-> !cand_mask[B_E]);

    // R9: the chosen direction is one of the candidates
    a_r9_pick_member: assert property (@(posedge clk) disable iff (!rst_n)
        cand_mask != '0 |-> (sel_dir == 3'd4 && cand_mask[B_L])
                         || (sel_dir < 3'd4 && cand_mask[sel_dir[1:0]]));

    // R9: no congestion anywhere keeps the x direction
    a_r9_x_default: assert property (@(posedge clk) disable iff (!rst_n)
        live_q && $past(cong_hint) == 4'b0000 && (cand_mask[B_E] || cand_mask[B_W])
        |-> sel_dir == 3'd0 || sel_dir == 3'd1);

    // R10: an empty candidate set reports no direction
    a_r10_empty_none: assert property (@(posedge clk) disable iff (!rst_n)
        cand_mask == '0 |-> sel_dir == 3'd7);

endmodule

// File: tb/oer_route_unit_bench.sv
`timescale 1ns/1ps
module oer_route_unit_bench;

    localparam int X_W = 3;
    localparam int Y_W = 3;
    localparam int NX  = 1 << X_W;
    localparam int NY  = 1 << Y_W;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [X_W-1:0] cur_x = '0;
    logic [Y_W-1:0] cur_y = '0;
    logic [X_W-1:0] dst_x = '0;
    logic [Y_W-1:0] dst_y = '0;
    logic [2:0]     arr_port = 3'd4;
    logic [3:0]     cong_hint = '0;
    logic [4:0]     cand_mask;
    logic [2:0]     sel_dir;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    oer_route_unit #(.X_W(X_W), .Y_W(Y_W)) u_oer_route_unit (
        .clk       (clk),
        .rst_n     (rst_n),
        .cur_x     (cur_x),
        .cur_y     (cur_y),
        .dst_x     (dst_x),
        .dst_y     (dst_y),
        .arr_port  (arr_port),
        .cong_hint (cong_hint),
        .cand_mask (cand_mask),
        .sel_dir   (sel_dir)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // behavioural model: distance-reducing set, then the turn-model removals
    function automatic void ref_route(input int cx, input int cy, input int dx,
                                      input int dy, input int arr, input int hint,
                                      output int m, output int s);
        int ex = dx - cx;
        int ey = dy - cy;
        bit e, w, n, so, xb, yb;
        bit east_trav = (arr == 1);
        bit vert_trav = (arr == 2) || (arr == 3);
        if (ex == 0 && ey == 0) begin
            m = 16; s = 4;
            return;
        end
        e = ex > 0; w = ex < 0; n = ey > 0; so = ey < 0;
        if (w && (cx % 2) == 1) begin n = 0; so = 0; end
        if (ex == 1 && (dx % 2) == 0 && ey != 0) e = 0;
        if (east_trav && (cx % 2) == 0) begin n = 0; so = 0; end
        if (vert_trav && (cx % 2) == 1) w = 0;
        m = int'(e) + 2 * int'(w) + 4 * int'(n) + 8 * int'(so);
        if (m == 0) s = 7;
        else if ((e || w) && (n || so)) begin
            xb = e ? hint[0] : hint[1];
            yb = n ? hint[2] : hint[3];
            if (xb && !yb) s = n ? 2 : 3;
            else s = e ? 0 : 1;
        end
        else if (e) s = 0;
        else if (w) s = 1;
        else if (n) s = 2;
        else s = 3;
    endfunction

    function automatic string tag_for(input int cx, input int cy, input int dx,
                                      input int dy, input int arr);
        if (cx == dx && cy == dy) return "R3";
        if (arr == 1 && (cx % 2) == 0) return "R5";
        if ((arr == 2 || arr == 3) && (cx % 2) == 1) return "R6";
        if (dx < cx) return "R7";
        if (dx == cx + 1 && (dx % 2) == 0 && dy != cy) return "R8";
        if (dx > cx && dy != cy) return "R9";
        return "R4";
    endfunction

    // called at a falling edge: drive, let one rising edge pass, compare
    task automatic step(input int cx, input int cy, input int dx, input int dy,
                        input int arr, input int hint, input string tag);
        int m, s;
        cur_x = X_W'(cx); cur_y = Y_W'(cy);
        dst_x = X_W'(dx); dst_y = Y_W'(dy);
        arr_port = 3'(arr); cong_hint = 4'(hint);
        @(negedge clk);
        ref_route(cx, cy, dx, dy, arr, hint, m, s);
        chk(int'(cand_mask) == m, tag, "cand_mask", int'(cand_mask), m);
        chk(int'(sel_dir) == s, tag, "sel_dir", int'(sel_dir), s);
    endtask

    initial begin
        #(5.0 * 190000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int cx, cy, hops, mh, i;
        int arr;
        logic [4:0] held_m;
        repeat (3) @(negedge clk);
        chk(cand_mask == 5'd0, "R1", "cand_mask in reset", int'(cand_mask), 0);
        chk(sel_dir == 3'd7, "R1", "sel_dir in reset", int'(sel_dir), 7);
        rst_n = 1'b1;
        @(negedge clk);

        // directed corners
        step(2, 3, 2, 3, 0, 15, "R3");
        step(2, 3, 2, 3, 1, 0, "R3");
        chk(cand_mask == 5'b10000, "R3", "local mask", int'(cand_mask), 16);
        step(4, 1, 6, 5, 1, 0, "R5");
        chk(cand_mask == 5'b00001, "R5", "no turn", int'(cand_mask), 1);
        step(3, 2, 1, 2, 3, 0, "R6");
        chk(cand_mask == 5'b00000, "R6", "west dropped", int'(cand_mask), 0);
        step(3, 2, 5, 6, 3, 0, "R6");
        step(3, 4, 0, 6, 4, 0, "R7");
        chk(cand_mask == 5'b00010, "R7", "odd column west only", int'(cand_mask), 2);
        step(2, 4, 0, 6, 4, 0, "R7");
        chk(cand_mask == 5'b00110, "R7", "even column west/north", int'(cand_mask), 6);
        step(3, 0, 4, 5, 4, 0, "R8");
        chk(cand_mask == 5'b00100, "R8", "east held", int'(cand_mask), 4);
        step(3, 0, 5, 5, 4, 0, "R8");
        step(1, 1, 5, 5, 4, 4'b0001, "R9");
        chk(sel_dir == 3'd2, "R9", "busy east gives north", int'(sel_dir), 2);
        step(1, 1, 5, 5, 4, 4'b0101, "R9");
        chk(sel_dir == 3'd0, "R9", "both busy keeps east", int'(sel_dir), 0);
        step(6, 6, 1, 1, 4, 4'b1010, "R9");
        step(6, 3, 1, 0, 6, 0, "R11");
        chk(cand_mask == 5'b01010, "R11", "code 6 as injected", int'(cand_mask), 10);
        step(6, 3, 1, 0, 7, 4'b0010, "R11");

        // R2: new inputs do not reach the outputs before the next rising edge
        step(0, 0, 7, 0, 4, 0, "R2");
        held_m = cand_mask;
        cur_x = 3'd7; dst_x = 3'd0; arr_port = 3'd4;
        #1;
        chk(cand_mask == held_m, "R2", "held between edges", int'(cand_mask), int'(held_m));
        @(negedge clk);
        chk(cand_mask == 5'b00010, "R2", "after one edge", int'(cand_mask), 2);

        // full sweep of node, destination and arrival
        i = 0;
        for (int x = 0; x < NX; x++)
            for (int y = 0; y < NY; y++)
                for (int tx = 0; tx < NX; tx++)
                    for (int ty = 0; ty < NY; ty++)
                        for (int a = 0; a < 5; a++) begin
                            step(x, y, tx, ty, a, (i * 7) & 15, tag_for(x, y, tx, ty, a));
                            i++;
                        end

        // R10: hop-by-hop walks steered by the unit's own choice
        for (int sx = 0; sx < NX; sx++)
            for (int sy = 0; sy < NY; sy++)
                for (int tx = 0; tx < NX; tx++)
                    for (int ty = 0; ty < NY; ty++) begin
                        cx = sx; cy = sy; arr = 4; hops = 0;
                        mh = (tx > sx ? tx - sx : sx - tx) + (ty > sy ? ty - sy : sy - ty);
                        while (hops <= 16) begin
                            step(cx, cy, tx, ty, arr, (hops * 5 + sx + ty) & 15, "R10");
                            if (cand_mask == 5'd0) begin
                                chk(1'b0, "R10", "empty mask on walk", 0, 1);
                                break;
                            end
                            if (sel_dir == 3'd4) break;
                            unique case (sel_dir)
                                3'd0: begin cx++; arr = 1; end
                                3'd1: begin cx--; arr = 0; end
                                3'd2: begin cy++; arr = 3; end
                                default: begin cy--; arr = 2; end
                            endcase
                            hops++;
                        end
                        chk(cx == tx && cy == ty && hops == mh, "R10", "hops to arrive",
                            hops, mh);
                    end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule